// File: doc/BRIEF.md
# DMA Sample Counter with Interrupt

This block counts the samples moved by a DMA sequencer and raises an interrupt once a programmed number of samples has passed. Software writes a 16-bit base count as two byte registers. Writing the upper byte copies the full base value into a hidden current count. Each sample-done pulse from the sequencer lowers that count by one.

A sample that arrives while the current count is already zero is the interrupt event. A base value of N therefore gives one interrupt every N+1 samples. On that event the current count reloads from the base registers, so transfers can continue without software writing the count again. The interrupt flag can always be read in the status register. The external interrupt pin follows the flag only while the enable bit is set. Any write to the status register clears the flag.

Top module: `dma_sample_counter`

## Requirements
- R1: After reset the base count bytes, the enable bit, the interrupt flag and the current count are all zero, and `irq` is low.
- R2: A write to address 1 (upper byte) loads the current count with {written byte, lower base byte}. A write to address 0 (lower byte) alone leaves the current count unchanged.
- R3: Reading address 0 returns the lower base byte last written, and reading address 1 returns the upper base byte last written. The current count is not visible at any address.
- R4: Each cycle with `sample_done` high and no upper-byte write lowers a non-zero current count by exactly one.
- R5: A `sample_done` while the current count is zero sets the interrupt flag, so a base value of N sets the flag on sample N+1 after loading.
- R6: Address 3 bit 0 reads the interrupt flag. `irq` is high only when the flag is set and the enable bit (address 2 bit 0) is 1; otherwise it stays low whatever the flag holds.
- R7: On the interrupt event the current count reloads from the base registers, so the next event follows after another base+1 samples.
- R8: Any write to address 3 clears the flag. If an interrupt event happens in the same cycle, the flag stays set.
- R9: An upper-byte write takes priority over `sample_done` in the same cycle. The sample is not counted and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 lower base, 1 upper base, 2 control, 3 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| sample_done | input | 1 | One-cycle pulse per transferred sample |
| irq | output | 1 | External interrupt pin |

## Verification
The counting path is tried with base values 0, 1, 3, 7, 9 and 258. The zero base shows that the event fires on the first sample. The small values separate N from N+1 counting. The value 258 needs both bytes, so it shows whether the upper byte reaches the count. A lower-byte-only rewrite separates the load that an upper-byte write performs from a reload at the event. A status write in the same cycle as a sample at count zero shows which of the two wins. A sample in the same cycle as an upper-byte write shows that the load takes priority. Running with the enable bit cleared and then set separates the status bit from the pin.

// File: rtl/dma_sample_counter.sv
module dma_sample_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          sample_done,
  output logic          irq
);
  localparam int CW = 2 * DW;

  logic [DW-1:0] base_lo, base_hi;
  logic [CW-1:0] cur;
  logic          ien, flag;

  wire wr_lo   = reg_wr && reg_addr == 2'd0;
  wire wr_hi   = reg_wr && reg_addr == 2'd1;
  wire wr_ctl  = reg_wr && reg_addr == 2'd2;
  wire wr_st   = reg_wr && reg_addr == 2'd3;
  wire counted = sample_done && !wr_hi;
  wire at_zero = cur == '0;
  wire fire    = counted && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo <= '0;
      base_hi <= '0;
      cur     <= '0;
      ien     <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (wr_lo)  base_lo <= reg_wdata;
      if (wr_ctl) ien     <= reg_wdata[0];
      if (wr_hi) begin
        base_hi <= reg_wdata;
        cur     <= {reg_wdata, base_lo};
      end else if (counted) begin
        cur <= at_zero ? {base_hi, base_lo} : cur - 1'b1;
      end
      if (fire)       flag <= 1'b1;
      else if (wr_st) flag <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      2'd0: reg_rdata = base_lo;
      2'd1: reg_rdata = base_hi;
      2'd2: reg_rdata = {{(DW-1){1'b0}}, ien};
      default: reg_rdata = {{(DW-1){1'b0}}, flag};
    endcase
  end

  assign irq = flag & ien;
endmodule

// File: rtl/dma_sample_counter_chk.sv
module dma_sample_counter_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [1:0]      reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic            sample_done,
  input logic            irq,
  input logic [DW-1:0]   base_lo,
  input logic [DW-1:0]   base_hi,
  input logic [2*DW-1:0] cur,
  input logic            ien,
  input logic            flag
);
  wire hi_w = reg_wr && reg_addr == 2'd1;
  wire st_w = reg_wr && reg_addr == 2'd3;
  wire ev   = sample_done && !hi_w && cur == '0;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_w |=> cur == {$past(reg_wdata), $past(base_lo)});

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_done && !hi_w && cur != '0) |=> cur == $past(cur) - 1'b1);

  p_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> flag);

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> cur == {$past(base_hi), $past(base_lo)});

  p_pin_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w && !ev) |=> !flag);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !sample_done) |=> $stable(cur));
endmodule

bind dma_sample_counter dma_sample_counter_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .sample_done(sample_done), .irq(irq),
  .base_lo(base_lo), .base_hi(base_hi), .cur(cur), .ien(ien), .flag(flag)
);

// File: tb/test_dma_sample_counter.sv
`timescale 1ns/1ps
module test_dma_sample_counter;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       sample_done = 0;
  logic       irq;

  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  dma_sample_counter i_dma_sample_counter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sample_done(sample_done), .irq(irq)
  );

  // {base count, samples until the flag sets}
  localparam logic [31:0] VEC [6] = '{
    {16'd0, 16'd1}, {16'd1, 16'd2}, {16'd3, 16'd4},
    {16'd7, 16'd8}, {16'h0102, 16'd259}, {16'd9, 16'd10}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sample_done = 1;
      @(negedge clk); sample_done = 0;
    end
  endtask

  task automatic expect_flag(input bit f, input string req);
    logic [7:0] d;
    rd(2'd3, d);
    check(d[0] == f, req, d[0], f);
  endtask

  initial begin
    #4_000_000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == 0, "R1 reset reg", d, 0);
    end
    check(irq == 0, "R1 reset irq", irq, 0);

    // R6: disabled pin stays low with flag set
    pulses(1);
    expect_flag(1, "R5 zero base fires on first sample");
    check(irq == 0, "R6 irq gated off", irq, 0);
    wr(2'd2, 8'h01);
    rd(2'd2, d);
    check(d[0] == 1, "R6 enable readback", d, 1);
    check(irq == 1, "R6 irq follows flag", irq, 1);
    wr(2'd3, 0);
    expect_flag(0, "R8 status write clears");

    foreach (VEC[k]) begin
      wr(2'd0, VEC[k][23:16]);
      wr(2'd1, VEC[k][31:24]);
      rd(2'd0, d); check(d == VEC[k][23:16], "R3 lower readback", d, VEC[k][23:16]);
      rd(2'd1, d); check(d == VEC[k][31:24], "R3 upper readback", d, VEC[k][31:24]);
      wr(2'd3, 0);
      pulses(int'(VEC[k][15:0]) - 1);
      expect_flag(0, "R4 no flag before N+1");
      check(irq == 0, "R6 irq low before event", irq, 0);
      pulses(1);
      expect_flag(1, "R5 flag on sample N+1");
      check(irq == 1, "R6 irq high on event", irq, 1);
    end

    // R7: reload from base (9) after the last event
    wr(2'd3, 0);
    pulses(9);
    expect_flag(0, "R7 reload no early flag");
    pulses(1);
    expect_flag(1, "R7 reload fires after base+1");

    // R2: lower write alone does not load the current count
    wr(2'd0, 8'd5); wr(2'd1, 8'd0); wr(2'd3, 0);
    wr(2'd0, 8'd2);
    pulses(5);
    expect_flag(0, "R2 lower write did not load");
    pulses(1);
    expect_flag(1, "R2 count from upper-write load");
    wr(2'd3, 0);
    pulses(2);
    expect_flag(0, "R7 reload uses new lower byte");
    pulses(1);
    expect_flag(1, "R7 new base event");

    // R8: clear and event in the same cycle, event wins
    wr(2'd0, 0); wr(2'd1, 0);
    pulses(1);
    @(negedge clk);
    reg_wr = 1; reg_addr = 2'd3; sample_done = 1;
    @(negedge clk);
    reg_wr = 0; sample_done = 0;
    expect_flag(1, "R8 event beats clear");
    wr(2'd3, 0);
    expect_flag(0, "R8 plain clear");

    // R9: sample during upper write is not counted
    wr(2'd0, 8'd2);
    @(negedge clk);
    reg_wr = 1; reg_addr = 2'd1; reg_wdata = 0; sample_done = 1;
    @(negedge clk);
    reg_wr = 0; sample_done = 0;
    expect_flag(0, "R9 no event on load cycle");
    pulses(2);
    expect_flag(0, "R9 sample not counted");
    pulses(1);
    expect_flag(1, "R9 event after full count");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule